// File: doc/BRIEF.md
# Link PHY Power-Up Sequencer

This block brings the analog front end of a display link transmitter out of power-down in a fixed order. On a start request it first programs a link-rate select (the lowest serial rate, or an LVDS code when LVDS mode is chosen). It then holds every power-down control asserted and releases them one group at a time: I/O deep power-down first, then the bandgap, then the PLL, VCO and PLL capacitor together, and last the port. Settling delays between releases are counted in pulses of a one-microsecond strobe. Pad calibration power-down is left asserted throughout.

The sequence runs once. After it completes, a sticky powered flag is set and later start requests are acknowledged at once, with no output change. A request is treated the same way when an external status reports that lane 0 is already powered. Busy marks a running sequence, and a one-cycle done pulse marks the end of every accepted request.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset all seven power-down outputs are 1, `spd_sel_o` is 0, and `busy_o`, `done_o` and `powered_o` are 0.
- R2: A start seen in idle with `powered_o`=0 and `lane0_up_i`=0 sets `spd_sel_o` on that edge to `SPD_LOW` (default 8'h06), or to `SPD_LVDS` (default 8'h07) when `lvds_mode_i`=1. No power-down output changes on that edge.
- R3: Two cycles after the start is accepted, `io_dpd_o` falls while every other power-down output is still 1.
- R4: `pd_bg_o` falls on the edge of the `DLY_DPD`-th (default 15) tick after the `io_dpd_o` release. A tick present on the release edge itself does not count.
- R5: `pd_pll_o`, `pd_vco_o` and `pd_cap_o` fall together on the edge of the `DLY_BG`-th (default 25) tick after the bandgap release.
- R6: `pd_port_o` falls on the edge of the `DLY_CORE`-th (default 225) tick after the PLL release. `pd_cal_o` remains 1.
- R7: On the edge that releases the port, `powered_o` becomes 1 and stays 1 until reset. `done_o` goes high for exactly one cycle.
- R8: `busy_o` is 1 from the cycle after a start is accepted until the cycle in which `done_o` is high; in that cycle, and in idle, it is 0.
- R9: A start seen in idle while `powered_o`=1 or `lane0_up_i`=1 produces `done_o` in the next cycle. `busy_o` stays 0, and neither `spd_sel_o` nor any power-down output changes.
- R10: A start asserted while `busy_o`=1 has no effect. The running sequence keeps its timing, and exactly one done pulse results.
- R11: Once a power-down output has been released it is never reasserted until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| start_i | input | 1 | Power-up request, sampled in idle |
| lvds_mode_i | input | 1 | Selects the LVDS rate code instead of the lowest serial rate |
| lane0_up_i | input | 1 | Lane 0 already reports powered; the request is skipped |
| us_tick_i | input | 1 | One-cycle strobe once per microsecond |
| spd_sel_o | output | SPD_W | Link-rate select |
| pd_port_o | output | 1 | Port power-down |
| pd_pll_o | output | 1 | PLL power-down |
| pd_bg_o | output | 1 | Bandgap power-down |
| pd_vco_o | output | 1 | VCO power-down |
| pd_cap_o | output | 1 | PLL capacitor power-down |
| io_dpd_o | output | 1 | I/O deep power-down |
| pd_cal_o | output | 1 | Pad calibration power-down |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse ending each accepted request |
| powered_o | output | 1 | Sticky power-up complete flag |

## Verification
The assertions assume that `us_tick_i` is a single-cycle strobe driven synchronously to `clk` and that each delay parameter is at least 1. They also assume `rst_n` is released synchronously, and that `lane0_up_i` does not fall on its own while a sequence is running. The stimulus drives every input one nanosecond after a rising edge. It generates ticks from a fixed irregular pattern so that tick counts and cycle counts differ. Before it raises `lane0_up_i` it applies a reset, and it asserts that input only while the block is idle.

// File: rtl/phy_pwrup_pkg.sv
package phy_pwrup_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ALL   = 3'd1,
    S_DPD   = 3'd2,
    S_WBG   = 3'd3,
    S_WCORE = 3'd4,
    S_WPORT = 3'd5
  } seq_st_t;

  typedef enum logic [2:0] {
    A_HOLD = 3'd0,
    A_ALL  = 3'd1,
    A_DPD  = 3'd2,
    A_BG   = 3'd3,
    A_CORE = 3'd4,
    A_PORT = 3'd5
  } pd_act_t;

  typedef struct packed {
    logic port;
    logic pll;
    logic bg;
    logic vco;
    logic cap;
    logic dpd;
    logic cal;
  } pd_vec_t;

endpackage

// File: rtl/pwrup_tick_timer.sv
module pwrup_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             fire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // load wins over a tick on the same edge
  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (tick_i && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire_o = tick_i && (cnt_q == CNT_W'(1));

  // R4: an expired counter stays at rest until reloaded
  a_r4_timer_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/pwrup_pd_bank.sv
module pwrup_pd_bank
  import phy_pwrup_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pd_act_t act_i,
  output pd_vec_t pd_o
);

  pd_vec_t pd_q, pd_d;

  always_comb begin
    pd_d = pd_q;
    case (act_i)
      A_ALL:  pd_d = '1;
      A_DPD:  pd_d.dpd = 1'b0;
      A_BG:   pd_d.bg  = 1'b0;
      A_CORE: begin
        pd_d.pll = 1'b0;
        pd_d.vco = 1'b0;
        pd_d.cap = 1'b0;
      end
      A_PORT: pd_d.port = 1'b0;
      default: pd_d = pd_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= '1;
    else        pd_q <= pd_d;
  end

  assign pd_o = pd_q;

  // R3: deep power-down leaves first, alone
  a_r3_dpd_alone: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q.dpd) |-> (pd_q.port && pd_q.pll && pd_q.bg && pd_q.vco && pd_q.cap));

  // R5: PLL, VCO and capacitor released on one edge
  a_r5_core_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q.pll) |-> ($fell(pd_q.vco) && $fell(pd_q.cap) && !pd_q.bg));

  // R6: port goes last and calibration stays down
  a_r6_port_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q.port) |-> (!pd_q.pll && !pd_q.bg && !pd_q.dpd && pd_q.cal));

  // R11: no control is reasserted once released
  a_r11_no_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(pd_q)) & pd_q) == '0);

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import phy_pwrup_pkg::*;
#(
  parameter int             SPD_W    = 8,
  parameter logic [SPD_W-1:0] SPD_LOW  = 8'h06,
  parameter logic [SPD_W-1:0] SPD_LVDS = 8'h07,
  parameter int             DLY_DPD  = 15,
  parameter int             DLY_BG   = 25,
  parameter int             DLY_CORE = 225
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             lvds_mode_i,
  input  logic             lane0_up_i,
  input  logic             us_tick_i,
  output logic [SPD_W-1:0] spd_sel_o,
  output logic             pd_port_o,
  output logic             pd_pll_o,
  output logic             pd_bg_o,
  output logic             pd_vco_o,
  output logic             pd_cap_o,
  output logic             io_dpd_o,
  output logic             pd_cal_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             powered_o
);

  localparam int DLY_M1  = (DLY_DPD > DLY_BG) ? DLY_DPD : DLY_BG;
  localparam int DLY_MAX = (DLY_M1 > DLY_CORE) ? DLY_M1 : DLY_CORE;
  localparam int CNT_W   = $clog2(DLY_MAX + 1);

  seq_st_t          st_q, st_d;
  logic [SPD_W-1:0] spd_q, spd_d;
  logic             pwr_q, pwr_d;
  logic             done_q, done_d;
  pd_act_t          act;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_fire;
  logic             skip;
  pd_vec_t          pd;

  assign skip = pwr_q | lane0_up_i;

  // next-state and action decode
  always_comb begin
    st_d     = st_q;
    spd_d    = spd_q;
    pwr_d    = pwr_q;
    done_d   = 1'b0;
    act      = A_HOLD;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          if (skip) begin
            done_d = 1'b1;
          end else begin
            spd_d = lvds_mode_i ? SPD_LVDS : SPD_LOW;
            st_d  = S_ALL;
          end
        end
      end
      S_ALL: begin
        act  = A_ALL;
        st_d = S_DPD;
      end
      S_DPD: begin
        act      = A_DPD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(DLY_DPD);
        st_d     = S_WBG;
      end
      S_WBG: begin
        if (tmr_fire) begin
          act      = A_BG;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(DLY_BG);
          st_d     = S_WCORE;
        end
      end
      S_WCORE: begin
        if (tmr_fire) begin
          act      = A_CORE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(DLY_CORE);
          st_d     = S_WPORT;
        end
      end
      S_WPORT: begin
        if (tmr_fire) begin
          act    = A_PORT;
          pwr_d  = 1'b1;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      spd_q  <= '0;
      pwr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      spd_q  <= spd_d;
      pwr_q  <= pwr_d;
      done_q <= done_d;
    end
  end

  pwrup_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .tick_i     (us_tick_i),
    .fire_o     (tmr_fire)
  );

  pwrup_pd_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (act),
    .pd_o  (pd)
  );

  assign spd_sel_o = spd_q;
  assign pd_port_o = pd.port;
  assign pd_pll_o  = pd.pll;
  assign pd_bg_o   = pd.bg;
  assign pd_vco_o  = pd.vco;
  assign pd_cap_o  = pd.cap;
  assign io_dpd_o  = pd.dpd;
  assign pd_cal_o  = pd.cal;
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = done_q;
  assign powered_o = pwr_q;

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: powered flag is sticky
  a_r7_powered_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    powered_o |=> powered_o);

  // R8: done never overlaps busy
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R9: skipped request acknowledges with no output change
  a_r9_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && start_i && skip) |=>
      (done_o && !busy_o && $stable(pd) && $stable(spd_q)));

  // R10: start while running neither restarts nor ends the run
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !tmr_fire) |=> (busy_o && $stable(spd_q)));

endmodule

// File: tb/phy_pwrup_seq_tb.sv
`timescale 1ns/100ps
module phy_pwrup_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, lvds, lane0, tick;
  logic [7:0] spd;
  logic       pd_port, pd_pll, pd_bg, pd_vco, pd_cap, io_dpd, pd_cal;
  logic       busy, done, powered;

  always #2.5 clk = ~clk;

  phy_pwrup_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lvds_mode_i(lvds),
    .lane0_up_i(lane0), .us_tick_i(tick), .spd_sel_o(spd),
    .pd_port_o(pd_port), .pd_pll_o(pd_pll), .pd_bg_o(pd_bg),
    .pd_vco_o(pd_vco), .pd_cap_o(pd_cap), .io_dpd_o(io_dpd),
    .pd_cal_o(pd_cal), .busy_o(busy), .done_o(done), .powered_o(powered)
  );

  typedef struct {
    logic [7:0] spd;
    logic [6:0] pd;
    int         ticks;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   done_cnt = 0;

  function automatic logic [6:0] pd_now();
    return {pd_port, pd_pll, pd_bg, pd_vco, pd_cap, io_dpd, pd_cal};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // tick pattern, irregular on purpose
  initial begin
    tick = 1'b0;
    for (int c = 0; ; c++) begin
      @(posedge clk); #1;
      tick = ((c % 3) == 0) || ((c % 7) == 5);
    end
  end

  // monitor: pops an expected item on every output change
  initial begin
    logic [14:0] prev, cur;
    int          tks;
    prev = '0;
    tks  = 0;
    forever begin
      @(negedge clk);
      cur = {spd, pd_now()};
      if (!rst_n) begin
        prev = cur;
        tks  = 0;
      end else begin
        if (done) done_cnt++;
        if (cur !== prev) begin
          if (exp_q.size() == 0) begin
            n_chk++; n_err++;
            $display("FAIL R11 unexpected change: actual=%0h expected=%0h", cur, prev);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.req, "spd", 32'(spd), 32'(e.spd));
            chk(e.req, "pd",  32'(pd_now()), 32'(e.pd));
            if (e.ticks >= 0) chk(e.req, "ticks", 32'(tks), 32'(e.ticks));
          end
          tks  = 0;
          prev = cur;
        end
        if (tick) tks++;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run_seq(logic mode, logic mid_start);
    logic [7:0] code;
    int         n0;
    code = mode ? 8'h07 : 8'h06;
    exp_q.push_back('{code, 7'b1111111, -1,  "R2"});
    exp_q.push_back('{code, 7'b1111101, -1,  "R3"});
    exp_q.push_back('{code, 7'b1101101, 15,  "R4"});
    exp_q.push_back('{code, 7'b1000001, 25,  "R5"});
    exp_q.push_back('{code, 7'b0000001, 225, "R6"});
    lvds = mode;
    n0 = done_cnt;
    pulse_start();
    @(negedge clk);
    chk("R8", "busy after start", 32'(busy), 32'd1);
    if (mid_start) begin
      repeat (40) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    chk("R7", "done seen", 32'(done), 32'd1);
    chk("R7", "powered", 32'(powered), 32'd1);
    chk("R8", "busy at done", 32'(busy), 32'd0);
    chk("R6", "releases pending", 32'(exp_q.size()), 32'd0);
    @(negedge clk);
    chk("R7", "done width", 32'(done), 32'd0);
    chk("R10", "done pulses", 32'(done_cnt - n0), 32'd1);
  endtask

  task automatic skip_req(string req, logic exp_pwr, logic [7:0] exp_spd, logic [6:0] exp_pd);
    pulse_start();
    @(negedge clk);
    chk(req, "skip done", 32'(done), 32'd1);
    chk(req, "skip busy", 32'(busy), 32'd0);
    chk(req, "skip spd", 32'(spd), 32'(exp_spd));
    chk("R11", "skip pd", 32'(pd_now()), 32'(exp_pd));
    chk(req, "skip powered", 32'(powered), 32'(exp_pwr));
    @(negedge clk);
    chk("R7", "skip done width", 32'(done), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; lvds = 1'b0; lane0 = 1'b0;
    do_reset();
    @(negedge clk);
    chk("R1", "pd", 32'(pd_now()), 32'h7F);
    chk("R1", "spd", 32'(spd), 32'd0);
    chk("R1", "busy/done/powered", 32'({busy, done, powered}), 32'd0);

    run_seq(1'b0, 1'b1);                     // R2..R8, R10
    skip_req("R9", 1'b1, 8'h06, 7'b0000001); // already powered
    repeat (20) @(negedge clk);

    do_reset();
    run_seq(1'b1, 1'b0);                     // LVDS code, R2

    do_reset();
    @(posedge clk); #1 lane0 = 1'b1;
    skip_req("R9", 1'b0, 8'h00, 7'b1111111); // lane 0 already up
    lane0 = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9", "no late change", 32'(pd_now()), 32'h7F);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule